// File: doc/BRIEF.md
# Signed/Unsigned Adder-Comparator with Carry and Zero Flags

This block is the arithmetic part of a processor's integer datapath. It takes a destination operand D, a source operand S, a four-bit operation code, and the incoming carry and zero flags. It produces a result word, a result write-enable, and new carry (C) and zero (Z) flags. All operations share one adder that is one bit wider than the data path. Both operands are first extended to that width: zero-extended for unsigned operations and sign-extended for signed ones.

The flag rules are uniform across operation classes. For every subtract and every compare, C means "D is below S":
- the unsigned forms use the borrow;
- the signed forms use the sign bit of the extended result.

A signed add also reports that extended sign bit, not overflow. Only the two dedicated overflow-sum operations set C to signed overflow. The extended ("X") forms fold the incoming C into the arithmetic, and they keep Z set only if it was already set, so that multi-word values chain.

Outputs are registered. A request presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high. The outputs hold their value while no request is presented. The decode stage and the register file lie outside the block.

Top module: `alu_cflag_unit`

Operation codes (`in_op`): 0 ADD, 1 ADDX, 2 ADDS, 3 ADDSX, 4 SUB, 5 SUBX, 6 SUBS, 7 SUBSX, 8 CMP, 9 CMPX, 10 CMPS, 11 CMPSX, 12 OVADD, 13 OVSUB, 14 and 15 reserved. For codes 0 to 11, bit 0 selects the extended form and bit 1 selects the signed form.

## Requirements
- R1: For SUB, SUBX, CMP and CMPX, C is 1 exactly when unsigned D is less than unsigned S plus the subtracted carry. The carry is the incoming C for the X forms and 0 otherwise. The result is D − S − carry, modulo 2^32.
- R2: For SUBS, SUBSX, CMPS and CMPSX, C is 1 exactly when signed D is less than signed S plus the subtracted carry. This is the sign bit of the 33-bit sign-extended difference. A compare and a subtract with the same operands give the same C.
- R3: For ADD and ADDX, the result is D + S + carry modulo 2^32, and C is the unsigned carry-out of bit 31.
- R4: For ADDS and ADDSX, C is the sign bit of the 33-bit sign-extended sum, not signed overflow. For example, 0x7FFFFFFF + 1 gives C = 0.
- R5: OVADD (D + S) and OVSUB (D − S) set C to 1 exactly on signed overflow of the 32-bit result.
- R6: For the extended forms (codes 1, 3, 5, 7, 9, 11), Z is 1 only if the result is zero and the incoming Z is 1.
- R7: For ADD, ADDS, SUB, SUBS, CMP, CMPS, OVADD and OVSUB, Z is 1 exactly when the 32-bit result is zero; the incoming Z is ignored.
- R8: For codes 8 to 11 (the compares), `out_wr` is 0 and `out_res` carries the difference. For codes 0 to 7, 12 and 13, `out_wr` is 1.
- R9: For the reserved codes 14 and 15, `out_wr` is 0, `out_res` is 0, and C and Z copy the incoming flags.
- R10: Outputs update one clock after a cycle with `in_valid` high, and `out_valid` follows `in_valid` with one cycle of delay. Outputs hold while `in_valid` is low. Synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_d | input | 32 | Destination operand D |
| in_s | input | 32 | Source operand S |
| in_c | input | 1 | Incoming carry flag |
| in_z | input | 1 | Incoming zero flag |
| out_valid | output | 1 | Result registered this cycle |
| out_res | output | 32 | Result word |
| out_wr | output | 1 | Result write-enable |
| out_c | output | 1 | New carry flag |
| out_z | output | 1 | New zero flag |

## Verification
The assertions check the following on every cycle, against the operands as they were sampled:
- the unsigned borrow rule of SUB;
- the signed less-than rule of SUBS and CMPS;
- the carry-out of ADD and the overflow of OVADD;
- the absence of a write for any compare;
- the flag pass-through of the reserved codes;
- the sticky zero of the extended forms;
- output hold when idle.

Only the bench's scenarios show the remaining behaviour: a signed add that overflows and still reports C = 0, extended chains that consume the incoming carry, the reset state, and the full result words across corner operands (0, 1, the most positive and most negative values, all ones). The bench compares each of these against a wide-integer model.

// File: rtl/alu_cflag_pkg.sv
package alu_cflag_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDX  = 4'd1,
        OP_ADDS  = 4'd2,
        OP_ADDSX = 4'd3,
        OP_SUB   = 4'd4,
        OP_SUBX  = 4'd5,
        OP_SUBS  = 4'd6,
        OP_SUBSX = 4'd7,
        OP_CMP   = 4'd8,
        OP_CMPX  = 4'd9,
        OP_CMPS  = 4'd10,
        OP_CMPSX = 4'd11,
        OP_OVADD = 4'd12,
        OP_OVSUB = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } op_e;

    // Control word driven by the decoder.
    typedef struct packed {
        logic legal;   // defined operation
        logic neg;     // subtract S instead of adding it
        logic sgn;     // sign-extend operands
        logic xtd;     // fold incoming carry, chain zero flag
        logic wr;      // write the result
        logic ovf;     // C reports signed overflow
    } ctl_t;

endpackage

// File: rtl/alu_cflag_decode.sv
module alu_cflag_decode
    import alu_cflag_pkg::*;
(
    input  logic [3:0] op,
    output ctl_t       ctl
);

    always_comb begin
        ctl = '0;
        unique case (op_e'(op))
            OP_ADD, OP_ADDX, OP_ADDS, OP_ADDSX: begin
                ctl.legal = 1'b1;
                ctl.neg   = 1'b0;
                ctl.sgn   = op[1];
                ctl.xtd   = op[0];
                ctl.wr    = 1'b1;
            end
            OP_SUB, OP_SUBX, OP_SUBS, OP_SUBSX: begin
                ctl.legal = 1'b1;
                ctl.neg   = 1'b1;
                ctl.sgn   = op[1];
                ctl.xtd   = op[0];
                ctl.wr    = 1'b1;
            end
            OP_CMP, OP_CMPX, OP_CMPS, OP_CMPSX: begin
                ctl.legal = 1'b1;
                ctl.neg   = 1'b1;
                ctl.sgn   = op[1];
                ctl.xtd   = op[0];
                ctl.wr    = 1'b0;
            end
            OP_OVADD, OP_OVSUB: begin
                ctl.legal = 1'b1;
                ctl.neg   = op[0];
                ctl.sgn   = 1'b1;
                ctl.wr    = 1'b1;
                ctl.ovf   = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/alu_cflag_core.sv
module alu_cflag_core
    import alu_cflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] d,
    input  logic [W-1:0] s,
    input  ctl_t         ctl,
    input  logic         cin,
    output logic [W:0]   ext
);

    localparam int EW = W + 1;

    logic [EW-1:0] d_ext;
    logic [EW-1:0] s_ext;
    logic [EW-1:0] s_term;
    logic          ci;

    always_comb begin
        // Both operands are widened the same way before the single add.
        d_ext  = {ctl.sgn & d[W-1], d};
        s_ext  = {ctl.sgn & s[W-1], s};
        s_term = ctl.neg ? ~s_ext : s_ext;
        if (ctl.neg) begin
            ci = ctl.xtd ? ~cin : 1'b1;
        end else begin
            ci = ctl.xtd ? cin : 1'b0;
        end
        ext = d_ext + s_term + {{W{1'b0}}, ci};
    end

endmodule

// File: rtl/alu_cflag_flags.sv
module alu_cflag_flags
    import alu_cflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W:0]   ext,
    input  ctl_t         ctl,
    input  logic         cin,
    input  logic         zin,
    output logic [W-1:0] res,
    output logic         c,
    output logic         z,
    output logic         wr
);

    always_comb begin
        if (!ctl.legal) begin
            res = '0;
            c   = cin;
            z   = zin;
            wr  = 1'b0;
        end else begin
            res = ext[W-1:0];
            c   = ctl.ovf ? (ext[W] ^ ext[W-1]) : ext[W];
            z   = (ext[W-1:0] == '0) & (ctl.xtd ? zin : 1'b1);
            wr  = ctl.wr;
        end
    end

endmodule

// File: rtl/alu_cflag_unit.sv
module alu_cflag_unit
    import alu_cflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [3:0]   in_op,
    input  logic [W-1:0] in_d,
    input  logic [W-1:0] in_s,
    input  logic         in_c,
    input  logic         in_z,
    output logic         out_valid,
    output logic [W-1:0] out_res,
    output logic         out_wr,
    output logic         out_c,
    output logic         out_z
);

    ctl_t         ctl;
    logic [W:0]   ext;
    logic [W-1:0] nx_res;
    logic         nx_c;
    logic         nx_z;
    logic         nx_wr;

    alu_cflag_decode i_decode (
        .op  (in_op),
        .ctl (ctl)
    );

    alu_cflag_core #(.W(W)) i_core (
        .d   (in_d),
        .s   (in_s),
        .ctl (ctl),
        .cin (in_c),
        .ext (ext)
    );

    alu_cflag_flags #(.W(W)) i_flags (
        .ext (ext),
        .ctl (ctl),
        .cin (in_c),
        .zin (in_z),
        .res (nx_res),
        .c   (nx_c),
        .z   (nx_z),
        .wr  (nx_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
            out_wr    <= 1'b0;
            out_c     <= 1'b0;
            out_z     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res <= nx_res;
                out_wr  <= nx_wr;
                out_c   <= nx_c;
                out_z   <= nx_z;
            end
        end
    end

    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_SUB) |=> (out_c == ($past(in_d) < $past(in_s)))); // R1
    AST_SUBS_SIGNED_LT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op == OP_SUBS || in_op == OP_CMPS))
        |=> (out_c == ($signed($past(in_d)) < $signed($past(in_s))))); // R2
    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_ADD)
        |=> (out_c == (out_res < $past(in_d)))); // R3
    AST_OVADD_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_OVADD)
        |=> (out_c == (($past(in_d[W-1]) == $past(in_s[W-1])) &&
                       (out_res[W-1] != $past(in_d[W-1]))))); // R5
    AST_XTD_ZERO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op < 4'd12 && in_op[0] && !in_z) |=> !out_z); // R6
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op >= 4'd8 && in_op <= 4'd11) |=> !out_wr); // R8
    AST_RSV_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op >= 4'd14)
        |=> (!out_wr && out_c == $past(in_c) && out_z == $past(in_z))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_res) && $stable(out_c) && $stable(out_z)
                       && $stable(out_wr) && !out_valid)); // R10

endmodule

// File: tb/test_alu_cflag_unit.sv
module test_alu_cflag_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  in_op;
    logic [31:0] in_d;
    logic [31:0] in_s;
    logic        in_c;
    logic        in_z;
    logic        out_valid;
    logic [31:0] out_res;
    logic        out_wr;
    logic        out_c;
    logic        out_z;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    alu_cflag_unit #(.W(32)) i_alu_cflag_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_d(in_d), .in_s(in_s), .in_c(in_c), .in_z(in_z),
        .out_valid(out_valid), .out_res(out_res), .out_wr(out_wr),
        .out_c(out_c), .out_z(out_z)
    );

    localparam int NV = 19;
    localparam logic [3:0]  V_OP [NV] = '{4'd0, 4'd0, 4'd2, 4'd2, 4'd4, 4'd4, 4'd6, 4'd6,
                                          4'd8, 4'd10, 4'd1, 4'd1, 4'd5, 4'd11, 4'd12,
                                          4'd13, 4'd12, 4'd14, 4'd5};
    localparam logic [31:0] V_D [NV] = '{32'hFFFFFFFF, 32'h1, 32'h7FFFFFFF, 32'hFFFFFFFF,
                                         32'h1, 32'h5, 32'h80000000, 32'h1, 32'h3,
                                         32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h5,
                                         32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF,
                                         32'h1234, 32'h5};
    localparam logic [31:0] V_S [NV] = '{32'h1, 32'h2, 32'h1, 32'hFFFFFFFF, 32'h2, 32'h5,
                                         32'h1, 32'hFFFFFFFF, 32'h3, 32'h7FFFFFFF, 32'h0,
                                         32'h0, 32'h5, 32'h0, 32'h1, 32'h1, 32'h1,
                                         32'h5678, 32'h4};
    localparam logic V_CI [NV] = '{0,0,0,0,0,0,0,0,0,0,1,1,1,1,0,0,0,1,1};
    localparam logic V_ZI [NV] = '{0,0,0,0,0,0,0,0,0,0,1,0,1,1,0,0,0,0,1};
    localparam logic [31:0] V_RES [NV] = '{32'h0, 32'h3, 32'h80000000, 32'hFFFFFFFE,
                                           32'hFFFFFFFF, 32'h0, 32'h7FFFFFFF, 32'h2, 32'h0,
                                           32'h1, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                           32'h80000000, 32'h7FFFFFFF, 32'h0, 32'h0, 32'h0};
    localparam logic V_C [NV] = '{1,0,0,1,1,0,1,0,0,1,1,1,1,1,1,1,0,1,0};
    localparam logic V_Z [NV] = '{1,0,0,0,0,1,0,0,1,0,1,0,0,0,0,0,1,0,1};
    localparam logic V_W [NV] = '{1,1,1,1,1,1,1,1,0,0,1,1,1,0,1,1,1,0,1};

    function automatic string req_of(input logic [3:0] op, input int fld);
        // fld: 0 result, 1 carry, 2 zero, 3 write
        if (op >= 4'd14) return "R9";
        if (fld == 3) return "R8";
        if (fld == 2) return (op < 4'd12 && op[0]) ? "R6" : "R7";
        if (op >= 4'd12) return "R5";
        if (op < 4'd4) return op[1] ? "R4" : "R3";
        return op[1] ? "R2" : "R1";
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s,
                         input logic ci, input logic zi);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_d = d; in_s = s; in_c = ci; in_z = zi;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic model(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s,
                         input logic ci, input logic zi, output logic [31:0] r,
                         output logic rc, output logic rz, output logic rw);
        longint sd, ss, ud, us, t, cx;
        logic x;
        sd = {{32{d[31]}}, d};
        ss = {{32{s[31]}}, s};
        ud = {32'b0, d};
        us = {32'b0, s};
        x  = (op < 4'd12) && op[0];
        cx = (x && ci) ? 64'sd1 : 64'sd0;
        rc = 1'b0;
        t  = 0;
        if (op < 4'd4) begin
            t  = op[1] ? (sd + ss + cx) : (ud + us + cx);
            rc = op[1] ? (t < 0) : t[32];
        end else if (op < 4'd12) begin
            t  = op[1] ? (sd - ss - cx) : (ud - us - cx);
            rc = (t < 0);
        end else if (op < 4'd14) begin
            t  = (op == 4'd12) ? (sd + ss) : (sd - ss);
            rc = (t > 64'sh7FFFFFFF) || (t < -64'sh80000000);
        end
        if (op >= 4'd14) begin
            r = 32'h0; rc = ci; rz = zi; rw = 1'b0;
        end else begin
            r  = t[31:0];
            rz = (r == 32'h0) && (x ? zi : 1'b1);
            rw = !(op >= 4'd8 && op <= 4'd11);
        end
    endtask

    function automatic logic [31:0] pick(input int sel);
        case (sel)
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'h7FFFFFFF;
            3: return 32'h80000000;
            4: return 32'hFFFFFFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] er;
        logic ec, ez, ew;
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_d = '0; in_s = '0;
        in_c = 1'b0; in_z = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", "reset valid", {31'b0, out_valid}, 32'h0);
        chk("R10", "reset res", out_res, 32'h0);
        chk("R10", "reset flags", {29'b0, out_wr, out_c, out_z}, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            apply(V_OP[i], V_D[i], V_S[i], V_CI[i], V_ZI[i]);
            chk(req_of(V_OP[i], 0), "res", out_res, V_RES[i]);
            chk(req_of(V_OP[i], 1), "c", {31'b0, out_c}, {31'b0, V_C[i]});
            chk(req_of(V_OP[i], 2), "z", {31'b0, out_z}, {31'b0, V_Z[i]});
            chk(req_of(V_OP[i], 3), "wr", {31'b0, out_wr}, {31'b0, V_W[i]});
            chk("R10", "valid", {31'b0, out_valid}, 32'h1);
        end

        // R2: compare and subtract agree on the same signed operands
        apply(4'd7, 32'h80000000, 32'h7FFFFFFF, 1'b1, 1'b0);
        ec = out_c;
        apply(4'd11, 32'h80000000, 32'h7FFFFFFF, 1'b1, 1'b0);
        chk("R2", "cmpsx vs subsx c", {31'b0, out_c}, {31'b0, ec});

        // R10: hold while idle
        apply(4'd0, 32'h10, 32'h20, 1'b0, 1'b0);
        in_d = 32'hDEAD; in_s = 32'hBEEF; in_op = 4'd4;
        repeat (2) @(negedge clk);
        chk("R10", "hold res", out_res, 32'h30);
        chk("R10", "idle valid", {31'b0, out_valid}, 32'h0);

        // randomized against wide-integer model
        for (int k = 0; k < 600; k++) begin
            logic [3:0] op;
            logic [31:0] d, s;
            logic ci, zi;
            op = 4'($urandom_range(0, 15));
            d  = pick($urandom_range(0, 8));
            s  = pick($urandom_range(0, 8));
            ci = 1'($urandom);
            zi = 1'($urandom);
            model(op, d, s, ci, zi, er, ec, ez, ew);
            apply(op, d, s, ci, zi);
            chk(req_of(op, 0), "rnd res", out_res, er);
            chk(req_of(op, 1), "rnd c", {31'b0, out_c}, {31'b0, ec});
            chk(req_of(op, 2), "rnd z", {31'b0, out_z}, {31'b0, ez});
            chk(req_of(op, 3), "rnd wr", {31'b0, out_wr}, {31'b0, ew});
        end

        // R10: reset mid-stream clears outputs
        apply(4'd0, 32'hFFFFFFFF, 32'h1, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10", "reset clear", {out_res[30:0], out_c}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule